// File: doc/BRIEF.md
# Partial-Program Order Fingerprint Recorder

A page of memory cells is programmed in many short partial steps, and after each step the whole page is read back. This block watches those read-backs. For every bit position it notes the step number at which that bit was first seen at 0. The set of these step numbers depends on how the cells were made, so it works as a fingerprint of the page. Collection ends once enough of the page has programmed. It also ends when a step limit is reached, and in that case a timeout flag is raised. The block then reduces the recorded ranks to one fingerprint bit per cell. A cell gives 1 when its rank is above half of the largest rank recorded, and 0 otherwise.

An external sequencer issues the flash program and read commands. It pulses `start`, waits for `accepting`, and then feeds each page read as bytes. The first byte of a read carries `in_sop`, and a `step_done` pulse follows the last byte. Ranks are kept in an internal word-wide RAM. At termination the fingerprint is streamed out as bytes on consecutive cycles.

Top module: `fp_order_recorder`

## Requirements
- R1: After reset, `accepting`, `fp_valid`, `fp_last` and `timeout` are all 0.
- R2: A `start` pulse while idle zeroes every rank. This takes PAGE_BITS/WORD_W cycles, after which `accepting` rises with the step order at 1 and the programmed count at 0. `timeout` is also cleared by the start.
- R3: While `accepting`, a byte with `in_valid` high is page word k, where k counts bytes from the last byte marked `in_sop` (that byte is word 0). Bit j of word k is cell 8k+j. A cell whose bit is 0 and whose rank is still 0 gets the current step order as its rank.
- R4: A rank that is already non-zero never changes, even when the cell reads 1 and later 0 again.
- R5: Each `step_done` that does not end collection advances the step order by one.
- R6: At a `step_done`, collection ends when the count of ranked cells is at least ceil(PAGE_BITS*FILL_PCT/100). With the defaults this leaves room for unprogrammed cells.
- R7: If the count is still short at the `step_done` of step MAX_STEPS, collection ends and `timeout` is set to 1.
- R8: A fingerprint bit is 1 exactly when the cell's rank is strictly greater than floor(max rank / 2). Cells that were never ranked give 0.
- R9: Once collection ends, PAGE_BITS/WORD_W bytes are sent on consecutive cycles with `fp_valid` high. Byte k, bit j is fingerprint bit 8k+j, and `fp_last` marks the final byte. The block then returns to idle.
- R10: The following bytes are ignored: bytes with `in_valid` low, and bytes whose word index is PAGE_BITS/WORD_W or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new fingerprint (honoured while idle) |
| in_valid | input | 1 | Page byte strobe |
| in_sop | input | 1 | Marks word 0 of a page read |
| in_data | input | WORD_W | Page bits, 0 = programmed |
| step_done | input | 1 | End of one partial step and its read |
| accepting | output | 1 | Collection phase active |
| timeout | output | 1 | Step limit ended the last collection |
| fp_valid | output | 1 | Fingerprint byte valid |
| fp_data | output | WORD_W | Fingerprint byte |
| fp_last | output | 1 | Final fingerprint byte |

## Verification
Every internal error in this block reaches the ports at the end of collection. A mis-ranked cell, or a rank that was overwritten, flips a fingerprint bit, either directly or by moving the maximum and so the threshold. A wrong programmed count or a wrong step order shows up as termination at the wrong step, with `accepting` falling one step early or late and `timeout` set wrongly. The stimulus patterns include a faulty cell, rank glitches, bytes beyond the page and idle-strobe garbage. Each of these shifts the step count or at least one byte of the streamed fingerprint.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_CLEAR,
      PH_COLLECT,
      PH_READOUT
   } phase_t;

   // ceil(bits * pct / 100)
   function automatic int fill_target(input int bits, input int pct);
      return (bits * pct + 99) / 100;
   endfunction

endpackage

// File: rtl/fpr_rank_store.sv
module fpr_rank_store #(
   parameter int DEPTH  = 128,
   parameter int LANES  = 8,
   parameter int RANK_W = 10
) (
   input  logic                             clk,
   input  logic                             wr_en,
   input  logic [$clog2(DEPTH)-1:0]         wr_addr,
   input  logic [LANES*RANK_W-1:0]          wr_data,
   input  logic [$clog2(DEPTH)-1:0]         rd_addr,
   output logic [LANES*RANK_W-1:0]          rd_data
);
   localparam int DW = LANES * RANK_W;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/fpr_lane_update.sv
module fpr_lane_update #(
   parameter int LANES  = 8,
   parameter int RANK_W = 10
) (
   input  logic [LANES*RANK_W-1:0] old_ranks,
   input  logic [LANES-1:0]        cell_zero,
   input  logic [RANK_W-1:0]       order,
   output logic [LANES*RANK_W-1:0] new_ranks,
   output logic [LANES-1:0]        fresh
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [RANK_W-1:0] cur;
      assign cur      = old_ranks[g*RANK_W +: RANK_W];
      assign fresh[g] = cell_zero[g] && (cur == '0);
      assign new_ranks[g*RANK_W +: RANK_W] = fresh[g] ? order : cur;
   end

endmodule

// File: rtl/fpr_binarize.sv
module fpr_binarize #(
   parameter int LANES  = 8,
   parameter int RANK_W = 10
) (
   input  logic [LANES*RANK_W-1:0] ranks,
   input  logic [RANK_W-1:0]       thr,
   output logic [LANES-1:0]        bits
);
   for (genvar g = 0; g < LANES; g++) begin : g_cmp
      assign bits[g] = ranks[g*RANK_W +: RANK_W] > thr;
   end

endmodule

// File: rtl/fp_order_recorder.sv
module fp_order_recorder #(
   parameter int PAGE_BITS = 1024,
   parameter int WORD_W    = 8,
   parameter int RANK_W    = 10,
   parameter int MAX_STEPS = 1023,
   parameter int FILL_PCT  = 99
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic [WORD_W-1:0] in_data,
   input  logic              step_done,
   output logic              accepting,
   output logic              timeout,
   output logic              fp_valid,
   output logic [WORD_W-1:0] fp_data,
   output logic              fp_last
);
   import fpr_pkg::*;

   localparam int PAGE_WORDS = PAGE_BITS / WORD_W;
   localparam int AW         = $clog2(PAGE_WORDS);
   localparam int CW         = $clog2(PAGE_BITS + 1);
   localparam int DW         = WORD_W * RANK_W;
   localparam int TARGET     = fill_target(PAGE_BITS, FILL_PCT);

   localparam logic [AW:0]       PW_L     = (AW+1)'(PAGE_WORDS);
   localparam logic [AW-1:0]     LAST_W   = AW'(PAGE_WORDS - 1);
   localparam logic [CW-1:0]     TARGET_L = CW'(TARGET);
   localparam logic [RANK_W-1:0] LIMIT_L  = RANK_W'(MAX_STEPS);

   if (PAGE_BITS % WORD_W != 0) begin : g_bad_page
      $error("PAGE_BITS must be a multiple of WORD_W");
   end
   if (PAGE_WORDS < 2 || (1 << AW) != PAGE_WORDS) begin : g_bad_words
      $error("PAGE_BITS/WORD_W must be a power of two of at least 2");
   end
   if (MAX_STEPS < 1 || MAX_STEPS >= (1 << RANK_W)) begin : g_bad_limit
      $error("MAX_STEPS must fit in RANK_W bits and be non-zero");
   end
   if (FILL_PCT < 1 || FILL_PCT > 100) begin : g_bad_fill
      $error("FILL_PCT must be in 1..100");
   end

   phase_t            phase;
   logic [RANK_W-1:0] order;
   logic [RANK_W-1:0] max_rank;
   logic [CW-1:0]     prog_count;
   logic [AW:0]       word_idx;
   logic [AW-1:0]     sweep_idx;

   // word indexing for incoming page bytes
   logic [AW:0]   cur_idx;
   logic          word_in_page;
   logic          take_word;
   assign cur_idx      = in_sop ? '0 : word_idx;
   assign word_in_page = cur_idx < PW_L;
   assign take_word    = (phase == PH_COLLECT) && in_valid && word_in_page;

   // rank store ports
   logic          ram_we;
   logic [AW-1:0] ram_waddr;
   logic [AW-1:0] ram_raddr;
   logic [DW-1:0] ram_wdata;
   logic [DW-1:0] ram_rdata;
   logic [DW-1:0] upd_ranks;
   logic [WORD_W-1:0] fresh;
   logic [WORD_W-1:0] fp_bits;

   assign ram_raddr = (phase == PH_COLLECT) ? cur_idx[AW-1:0] : sweep_idx;
   assign ram_waddr = (phase == PH_CLEAR) ? sweep_idx : cur_idx[AW-1:0];
   assign ram_we    = (phase == PH_CLEAR) || take_word;
   assign ram_wdata = (phase == PH_CLEAR) ? '0 : upd_ranks;

   fpr_rank_store #(
      .DEPTH (PAGE_WORDS),
      .LANES (WORD_W),
      .RANK_W(RANK_W)
   ) u_store (
      .clk    (clk),
      .wr_en  (ram_we),
      .wr_addr(ram_waddr),
      .wr_data(ram_wdata),
      .rd_addr(ram_raddr),
      .rd_data(ram_rdata)
   );

   fpr_lane_update #(
      .LANES (WORD_W),
      .RANK_W(RANK_W)
   ) u_update (
      .old_ranks(ram_rdata),
      .cell_zero(~in_data),
      .order    (order),
      .new_ranks(upd_ranks),
      .fresh    (fresh)
   );

   fpr_binarize #(
      .LANES (WORD_W),
      .RANK_W(RANK_W)
   ) u_bin (
      .ranks(ram_rdata),
      .thr  (max_rank >> 1),
      .bits (fp_bits)
   );

   // number of cells newly ranked by the current byte
   logic [CW-1:0] fresh_cnt;
   always_comb begin
      fresh_cnt = '0;
      for (int i = 0; i < WORD_W; i++) begin
         fresh_cnt = fresh_cnt + CW'(take_word & fresh[i]);
      end
   end

   logic reached;
   assign reached = prog_count >= TARGET_L;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         order      <= '0;
         max_rank   <= '0;
         prog_count <= '0;
         word_idx   <= '0;
         sweep_idx  <= '0;
         timeout    <= 1'b0;
         fp_valid   <= 1'b0;
         fp_data    <= '0;
         fp_last    <= 1'b0;
      end else begin
         fp_valid <= 1'b0;
         fp_last  <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  phase     <= PH_CLEAR;
                  sweep_idx <= '0;
                  timeout   <= 1'b0;
               end
            end
            PH_CLEAR: begin
               sweep_idx <= sweep_idx + 1'b1;
               if (sweep_idx == LAST_W) begin
                  phase      <= PH_COLLECT;
                  order      <= RANK_W'(1);
                  max_rank   <= '0;
                  prog_count <= '0;
                  word_idx   <= '0;
               end
            end
            PH_COLLECT: begin
               if (in_valid) begin
                  word_idx <= word_in_page ? cur_idx + 1'b1 : PW_L;
               end
               if (take_word) begin
                  prog_count <= prog_count + fresh_cnt;
                  if (fresh != '0) max_rank <= order;
               end
               if (step_done) begin
                  if (reached) begin
                     phase     <= PH_READOUT;
                     sweep_idx <= '0;
                  end else if (order == LIMIT_L) begin
                     phase     <= PH_READOUT;
                     sweep_idx <= '0;
                     timeout   <= 1'b1;
                  end else begin
                     order <= order + 1'b1;
                  end
               end
            end
            PH_READOUT: begin
               fp_valid  <= 1'b1;
               fp_data   <= fp_bits;
               fp_last   <= (sweep_idx == LAST_W);
               sweep_idx <= sweep_idx + 1'b1;
               if (sweep_idx == LAST_W) phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign accepting = (phase == PH_COLLECT);

endmodule

// File: rtl/fpr_checker.sv
module fpr_checker #(
   parameter int RANK_W    = 10,
   parameter int CW        = 11,
   parameter int MAX_STEPS = 1023,
   parameter int PAGE_BITS = 1024
) (
   input logic              clk,
   input logic              rst_n,
   input logic              accepting,
   input logic              step_done,
   input logic              timeout,
   input logic              fp_valid,
   input logic              fp_last,
   input logic [RANK_W-1:0] order,
   input logic [RANK_W-1:0] max_rank,
   input logic [CW-1:0]     prog_count
);

   AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(accepting) |-> (order == RANK_W'(1) && prog_count == '0)); // R2

   AST_MAX_NOT_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
      accepting |-> max_rank <= order); // R3

   AST_MAX_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      (accepting && $past(accepting)) |-> max_rank >= $past(max_rank)); // R4

   AST_ORDER_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (accepting && step_done) |=> (!accepting || order == $past(order) + RANK_W'(1))); // R5

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      prog_count <= CW'(PAGE_BITS)); // R6

   AST_ORDER_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      order <= RANK_W'(MAX_STEPS)); // R7

   AST_TIMEOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> $past(accepting && step_done)); // R7

   AST_LAST_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      fp_last |-> fp_valid); // R9

   AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      fp_valid |-> !accepting); // R9

endmodule

bind fp_order_recorder fpr_checker #(
   .RANK_W   (RANK_W),
   .CW       (CW),
   .MAX_STEPS(MAX_STEPS),
   .PAGE_BITS(PAGE_BITS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .accepting (accepting),
   .step_done (step_done),
   .timeout   (timeout),
   .fp_valid  (fp_valid),
   .fp_last   (fp_last),
   .order     (order),
   .max_rank  (max_rank),
   .prog_count(prog_count)
);

// File: tb/fp_order_recorder_test.sv
module fp_order_recorder_test;
   localparam int PB     = 128;
   localparam int WW     = 8;
   localparam int NW     = PB / WW;
   localparam int MS     = 40;
   localparam int TARGET = (PB * 99 + 99) / 100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_sop = 1'b0;
   logic [WW-1:0] in_data = '0;
   logic          step_done = 1'b0;
   logic          accepting, timeout, fp_valid, fp_last;
   logic [WW-1:0] fp_data;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   int rank_e [PB];
   int exp_steps, exp_to, exp_max;

   always #5 clk = ~clk;

   fp_order_recorder #(
      .PAGE_BITS(PB), .WORD_W(WW), .RANK_W(10), .MAX_STEPS(MS), .FILL_PCT(99)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_sop(in_sop), .in_data(in_data), .step_done(step_done),
      .accepting(accepting), .timeout(timeout), .fp_valid(fp_valid),
      .fp_data(fp_data), .fp_last(fp_last)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // cell i reads 0 after step s under pattern pat
   function automatic bit rz(input int i, input int s, input int pat);
      int f;
      case (pat)
         0: begin
            if (i == 5) return 0;
            f = (i * 7) % 37 + 1;
            return s >= f;
         end
         1: begin
            if (i == 3 || i == 77) return 0;
            f = (i % 30) + 1;
            return s >= f;
         end
         2: begin
            f = (i * 11) % 13 + 1;
            if (i % 4 == 0) return (s == f) || (s >= f + 3);
            return s >= f;
         end
         default: begin
            if (i % 9 == 0) return 0;
            f = (i % 4) + 1;
            return s >= f;
         end
      endcase
   endfunction

   task automatic model(input int pat);
      int cnt = 0;
      exp_max = 0;
      exp_to = 0;
      exp_steps = MS;
      for (int i = 0; i < PB; i++) rank_e[i] = 0;
      for (int s = 1; s <= MS; s++) begin
         for (int i = 0; i < PB; i++) begin
            if (rank_e[i] == 0 && rz(i, s, pat)) begin
               rank_e[i] = s;
               cnt++;
               exp_max = s;
            end
         end
         if (cnt >= TARGET) begin exp_steps = s; break; end
         if (s == MS) exp_to = 1;
      end
   endtask

   task automatic send_page(input int s, input int pat);
      for (int w = 0; w < NW; w++) begin
         logic [WW-1:0] b;
         for (int j = 0; j < WW; j++) b[j] = !rz(w * WW + j, s, pat);
         in_valid = 1'b1; in_sop = (w == 0); in_data = b;
         @(negedge clk);
         if (w == 7) begin
            // R10: idle strobe with all-zero data must not rank anything
            in_valid = 1'b0; in_sop = 1'b0; in_data = '0;
            @(negedge clk);
         end
      end
      // R10: byte beyond the page end
      in_valid = 1'b1; in_sop = 1'b0; in_data = '0;
      @(negedge clk);
      in_valid = 1'b0; in_data = '1;
      step_done = 1'b1;
      @(negedge clk);
      step_done = 1'b0;
   endtask

   task automatic run_pat(input int pat);
      int steps = 0;
      int guard;
      int cnt;
      model(pat);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      guard = 0;
      while (!accepting && guard < 100) begin @(negedge clk); guard++; end
      chk(guard == NW, "R2 clear sweep length", guard, NW);
      chk(timeout == 1'b0, "R7 timeout cleared by start", timeout, 0);
      while (1) begin
         steps++;
         send_page(steps, pat);
         if (!accepting || steps > MS + 2) break;
      end
      chk(steps == exp_steps, exp_to ? "R7 steps at limit" : "R6 termination step", steps, exp_steps);
      chk(timeout == exp_to[0], "R7 timeout flag", timeout, exp_to);
      cnt = 0;
      guard = 0;
      while (cnt < NW && guard < 100) begin
         if (fp_valid) begin
            logic [WW-1:0] e;
            for (int j = 0; j < WW; j++) e[j] = rank_e[cnt * WW + j] > exp_max / 2;
            chk(fp_data == e, "R8 fingerprint byte (R3 R4 R10)", fp_data, e);
            chk(fp_last == (cnt == NW - 1), "R9 last marker", fp_last, cnt == NW - 1);
            cnt++;
         end
         @(negedge clk);
         guard++;
      end
      chk(cnt == NW, "R9 byte count", cnt, NW);
      chk(!fp_valid && !accepting, "R9 back to idle", fp_valid, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!accepting, "R1 accepting at reset", accepting, 0);
      chk(!fp_valid && !fp_last, "R1 output idle at reset", fp_valid, 0);
      chk(!timeout, "R1 timeout at reset", timeout, 0);
      run_pat(0);   // one faulty cell, normal end (R6)
      run_pat(1);   // two faulty cells, step limit (R7)
      run_pat(2);   // glitching cells keep first rank (R4)
      run_pat(3);   // many unranked cells, small ranks (R8)
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule